// File: doc/BRIEF.md
# Masked Multi-Lane Vector Arithmetic Unit

This unit runs one integer vector instruction at a time over a small on-chip vector register file. Each register holds a fixed number of 32-bit elements. Four lanes share the work, and lane k owns elements k, k+4, k+8 and so on. In each cycle every lane processes one element, so a group of four elements is written back per cycle. A run-time length register limits how many leading elements an instruction touches.

The supported operations are add, subtract and multiply. Each can take a second vector register or one scalar that is paired with every element. Equal and not-equal compares write one bit per element into one of two flag registers. An arithmetic instruction can be predicated on a chosen flag register, so that only elements with a set flag are updated.

An element access port lets the surrounding datapath fill and inspect registers. A flag read port exposes the flag registers. A done pulse marks the end of each instruction.

Top module: `vau_top`

## Requirements
- R1: After reset the length register reads 32, every vector element is zero, flag register 0 is all ones, flag register 1 is all zeros, `in_ready` is high and `done` is low.
- R2: A length write stores `len_wdata` when it is at most 32 and stores 32 otherwise. The stored value is visible on `len_q` in the cycle after the write edge.
- R3: The op codes are 0 = add, 1 = subtract (first source minus second) and 2 = multiply. For each element i below the length, the destination gets the low 32 bits of the result of `srca[i]` and `srcb[i]`.
- R4: With `in_scalar_form` set, the second operand of every element is the `scalar_in` value captured when the instruction is accepted.
- R5: Elements at an index at or above the length keep their old value. This holds for vector destinations and for flag bits.
- R6: Op code 3 (equal) and op code 4 (not equal) write flag register `in_dst[0]`. Bit i is set when the relation holds between `srca[i]` and the second operand, and cleared otherwise.
- R7: With `in_masked` set, element i of the destination is written only if bit i of flag register `in_msel` is set. Other elements keep their value.
- R8: An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. Let the length be n. `done` is high for exactly one cycle, which follows the ceil(n/4)-th edge after acceptance. `in_ready` is low before that cycle and high again in it.
- R9: A length of zero gives the `done` pulse in the cycle after the accepting edge and changes no register.
- R10: `in_valid` asserted while the unit is busy is not accepted and has no effect.
- R11: A length write during execution does not change the element count of the running instruction. It takes effect for later instructions.
- R12: An access-port write that hits the element being written back at the same edge loses to the instruction result. A write to an element outside the current group is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, can accept an instruction |
| in_op | input | 3 | Operation code |
| in_dst | input | 3 | Destination vector register, or flag register in bit 0 for compares |
| in_srca | input | 3 | First source vector register |
| in_srcb | input | 3 | Second source vector register |
| in_scalar_form | input | 1 | Use the scalar as second operand |
| in_masked | input | 1 | Predicate on a flag register |
| in_msel | input | 1 | Flag register used as predicate |
| scalar_in | input | 32 | Scalar operand |
| len_we | input | 1 | Length register write enable |
| len_wdata | input | 8 | Requested length |
| len_q | output | 6 | Current length |
| done | output | 1 | Instruction completion pulse |
| el_we | input | 1 | Element port write enable |
| el_reg | input | 3 | Element port register index |
| el_idx | input | 5 | Element port element index |
| el_wdata | input | 32 | Element port write data |
| el_rdata | output | 32 | Element port read data |
| mk_rsel | input | 1 | Flag register to read |
| mk_rdata | output | 32 | Flag register contents |

## Verification
Two events can fall on the same edge. One is an instruction writeback. The other is a write from the element port, or a length write, arriving while execution is under way. The bench starts a full-length instruction and counts edges from acceptance. It drives a port write onto the element that belongs to the group retiring at that edge, and a second one onto an element whose group has already retired. It expects the instruction result in the first element and the port value in the second. A length write and a competing instruction offered mid-run are judged by the full count of updated elements, the unchanged would-be destination, and the new `len_q`.

// File: rtl/vau_pkg.sv
`timescale 1ns/1ps
package vau_pkg;
    localparam int LANES     = 4;
    localparam int NREG      = 8;
    localparam int VLMAX     = 32;
    localparam int EW        = 32;
    localparam int NMASK     = 2;
    localparam int LEN_IN_W  = 8;
    localparam int SLOTS     = VLMAX / LANES;
    localparam int RW        = $clog2(NREG);
    localparam int IW        = $clog2(VLMAX);
    localparam int LW        = $clog2(VLMAX + 1);
    localparam int MW        = $clog2(NMASK);
    localparam int SW        = $clog2(SLOTS);
    localparam int KW        = $clog2(LANES);

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_CEQ = 3'd3,
        OP_CNE = 3'd4
    } vop_e;

    typedef struct packed {
        vop_e          op;
        logic [RW-1:0] dst;
        logic [RW-1:0] srca;
        logic [RW-1:0] srcb;
        logic          scal;
        logic          msk;
        logic [MW-1:0] msel;
        logic [EW-1:0] scalar;
    } vinstr_t;

    function automatic logic is_arith(vop_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
    endfunction

    function automatic logic is_cmp(vop_e op);
        return (op == OP_CEQ) || (op == OP_CNE);
    endfunction

    function automatic logic [EW-1:0] alu(vop_e op, logic [EW-1:0] a, logic [EW-1:0] b);
        case (op)
            OP_SUB:  return a - b;
            OP_MUL:  return a * b;
            default: return a + b;
        endcase
    endfunction

    function automatic logic relate(vop_e op, logic [EW-1:0] a, logic [EW-1:0] b);
        return (op == OP_CEQ) ? (a == b) : (a != b);
    endfunction
endpackage

// File: rtl/vau_seq.sv
`timescale 1ns/1ps
module vau_seq
    import vau_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] len_in,
    output logic          busy,
    output logic [SW-1:0] slot,
    output logic [LW-1:0] vl_run,
    output logic          done
);
    logic [LW-1:0] next_base;
    logic          last;

    assign next_base = LW'({slot, {KW{1'b0}}}) + LW'(LANES);
    assign last      = (next_base >= vl_run);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            slot   <= '0;
            vl_run <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                if (len_in == '0) begin
                    done <= 1'b1;
                end else begin
                    busy   <= 1'b1;
                    slot   <= '0;
                    vl_run <= len_in;
                end
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (start && len_in == '0) |=> (done && !busy));

    // R8
    last_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && last) |=> (done && !busy));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(vl_run));
endmodule

// File: rtl/vau_lane.sv
`timescale 1ns/1ps
module vau_lane
    import vau_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          act,
    input  logic [SW-1:0] slot,
    input  vop_e          op,
    input  logic [RW-1:0] dst,
    input  logic [RW-1:0] srca,
    input  logic [RW-1:0] srcb,
    input  logic          scal,
    input  logic          msk,
    input  logic [EW-1:0] scalar,
    input  logic          mbit,
    input  logic          pw_en,
    input  logic [RW-1:0] p_reg,
    input  logic [SW-1:0] p_slot,
    input  logic [EW-1:0] pw_data,
    output logic [EW-1:0] pr_data,
    output logic          cmp_bit
);
    logic [EW-1:0] rf [NREG][SLOTS];
    logic [EW-1:0] opa, opb;
    logic          wr_res;

    assign opa     = rf[srca][slot];
    assign opb     = scal ? scalar : rf[srcb][slot];
    assign cmp_bit = relate(op, opa, opb);
    assign wr_res  = act && is_arith(op) && (!msk || mbit);
    assign pr_data = rf[p_reg][p_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++)
                for (int s = 0; s < SLOTS; s++)
                    rf[r][s] <= '0;
        end else begin
            if (pw_en)
                rf[p_reg][p_slot] <= pw_data;
            if (wr_res)
                rf[dst][slot] <= alu(op, opa, opb);
        end
    end
endmodule

// File: rtl/vau_top.sv
`timescale 1ns/1ps
module vau_top
    import vau_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [2:0]          in_op,
    input  logic [RW-1:0]       in_dst,
    input  logic [RW-1:0]       in_srca,
    input  logic [RW-1:0]       in_srcb,
    input  logic                in_scalar_form,
    input  logic                in_masked,
    input  logic [MW-1:0]       in_msel,
    input  logic [EW-1:0]       scalar_in,
    input  logic                len_we,
    input  logic [LEN_IN_W-1:0] len_wdata,
    output logic [LW-1:0]       len_q,
    output logic                done,
    input  logic                el_we,
    input  logic [RW-1:0]       el_reg,
    input  logic [IW-1:0]       el_idx,
    input  logic [EW-1:0]       el_wdata,
    output logic [EW-1:0]       el_rdata,
    input  logic [MW-1:0]       mk_rsel,
    output logic [VLMAX-1:0]    mk_rdata
);
    logic                busy, start;
    logic [SW-1:0]       slot;
    logic [LW-1:0]       vl_run;
    vinstr_t             ins_q;
    logic [VLMAX-1:0]    masks [NMASK];
    logic [LANES-1:0]    act, cmp_bits, mbits;
    logic [EW-1:0]       rd_lane [LANES];

    assign in_ready = !busy;
    assign start    = in_valid && !busy;
    assign mk_rdata = masks[mk_rsel];
    assign el_rdata = rd_lane[el_idx[KW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= LW'(VLMAX);
        end else if (len_we) begin
            len_q <= (len_wdata > LEN_IN_W'(VLMAX)) ? LW'(VLMAX) : LW'(len_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_q <= '0;
        end else if (start) begin
            ins_q <= '{op: vop_e'(in_op), dst: in_dst, srca: in_srca, srcb: in_srcb,
                       scal: in_scalar_form, msk: in_masked, msel: in_msel,
                       scalar: scalar_in};
        end
    end

    vau_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .len_in (len_q),
        .busy   (busy),
        .slot   (slot),
        .vl_run (vl_run),
        .done   (done)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign act[k]   = busy && (LW'({slot, KW'(k)}) < vl_run);
        assign mbits[k] = masks[ins_q.msel][{slot, KW'(k)}];

        vau_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .act     (act[k]),
            .slot    (slot),
            .op      (ins_q.op),
            .dst     (ins_q.dst),
            .srca    (ins_q.srca),
            .srcb    (ins_q.srcb),
            .scal    (ins_q.scal),
            .msk     (ins_q.msk),
            .scalar  (ins_q.scalar),
            .mbit    (mbits[k]),
            .pw_en   (el_we && (el_idx[KW-1:0] == KW'(k))),
            .p_reg   (el_reg),
            .p_slot  (el_idx[IW-1:KW]),
            .pw_data (el_wdata),
            .pr_data (rd_lane[k]),
            .cmp_bit (cmp_bits[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int m = 0; m < NMASK; m++)
                masks[m] <= (m == 0) ? '1 : '0;
        end else if (is_cmp(ins_q.op)) begin
            for (int k = 0; k < LANES; k++)
                if (act[k])
                    masks[ins_q.dst[MW-1:0]][{slot, KW'(k)}] <= cmp_bits[k];
        end
    end

    // R2
    len_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        len_q <= LW'(VLMAX));

    // R1
    mask0_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (masks[0] == '1));

    // R10
    held_instr_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ins_q));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && len_q != '0) |=> !in_ready);
endmodule

// File: tb/test_vau_top.sv
`timescale 1ns/1ps
module test_vau_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [2:0]  in_dst = '0, in_srca = '0, in_srcb = '0;
    logic        in_scalar_form = 1'b0, in_masked = 1'b0;
    logic [0:0]  in_msel = '0;
    logic [31:0] scalar_in = '0;
    logic        len_we = 1'b0;
    logic [7:0]  len_wdata = '0;
    logic [5:0]  len_q;
    logic        done;
    logic        el_we = 1'b0;
    logic [2:0]  el_reg = '0;
    logic [4:0]  el_idx = '0;
    logic [31:0] el_wdata = '0;
    logic [31:0] el_rdata;
    logic [0:0]  mk_rsel = '0;
    logic [31:0] mk_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] mv [8][32];
    logic [31:0] mm [2];
    int mlen = 32;

    always #5 clk = ~clk;

    vau_top i_vau_top (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int r, input int i, input logic [31:0] v);
        @(negedge clk);
        el_we = 1'b1; el_reg = 3'(r); el_idx = 5'(i); el_wdata = v;
        @(negedge clk);
        el_we = 1'b0;
        mv[r][i] = v;
    endtask

    task automatic setlen(input int v);
        @(negedge clk);
        len_we = 1'b1; len_wdata = 8'(v);
        @(negedge clk);
        len_we = 1'b0;
        mlen = (v > 32) ? 32 : v;
    endtask

    task automatic check_all(input string tag);
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 32; i++) begin
                el_reg = 3'(r); el_idx = 5'(i); #1;
                chk($sformatf("%s v%0d[%0d]", tag, r, i), el_rdata, mv[r][i]);
            end
        for (int m = 0; m < 2; m++) begin
            mk_rsel = 1'(m); #1;
            chk($sformatf("%s flag%0d", tag, m), mk_rdata, mm[m]);
        end
    endtask

    task automatic model(input int op, input int d, input int a, input int b,
                         input bit sc, input bit mk, input int ms, input logic [31:0] s, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] x, y;
            x = mv[a][i];
            y = sc ? s : mv[b][i];
            if (op <= 2) begin
                if (!mk || mm[ms][i])
                    mv[d][i] = (op == 0) ? x + y : (op == 1) ? x - y : x * y;
            end else if (op <= 4) begin
                mm[d % 2][i] = (op == 3) ? (x == y) : (x != y);
            end
        end
    endtask

    task automatic issue(input int op, input int d, input int a, input int b,
                         input bit sc, input bit mk, input int ms, input logic [31:0] s);
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'(op); in_dst = 3'(d); in_srca = 3'(a); in_srcb = 3'(b);
        in_scalar_form = sc; in_masked = mk; in_msel = 1'(ms); scalar_in = s;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string tag, input int op, input int d, input int a, input int b,
                       input bit sc, input bit mk, input int ms, input logic [31:0] s);
        int ng;
        bit ok;
        issue(op, d, a, b, sc, mk, ms, s);
        model(op, d, a, b, sc, mk, ms, s, mlen);
        ng = (mlen + 3) / 4;
        ok = 1'b1;
        for (int c = 0; c <= ng; c++) begin
            if (c > 0) @(negedge clk);
            if (c < ng && (done !== 1'b0 || in_ready !== 1'b0)) ok = 1'b0;
            if (c == ng && (done !== 1'b1 || in_ready !== 1'b1)) ok = 1'b0;
        end
        @(negedge clk);
        if (done !== 1'b0) ok = 1'b0;
        chk($sformatf("R8 %s done timing", tag), 32'(ok), 32'd1);
    endtask

    task automatic wait_done();
        int c = 0;
        while (done !== 1'b1 && c < 100) begin
            @(negedge clk);
            c++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 len", 32'(len_q), 32'd32);
        chk("R1 ready", 32'(in_ready), 32'd1);
        chk("R1 done", 32'(done), 32'd0);
        check_all("R1 reset");
    endtask

    task automatic t_len();
        setlen(40);
        chk("R2 clamp 40", 32'(len_q), 32'd32);
        setlen(13);
        chk("R2 write 13", 32'(len_q), 32'd13);
    endtask

    task automatic t_vv();
        setlen(32);
        run("R3 add", 0, 3, 1, 2, 0, 0, 0, 0);
        run("R3 sub", 1, 4, 1, 2, 0, 0, 0, 0);
        run("R3 mul", 2, 5, 1, 2, 0, 0, 0, 0);
        check_all("R3 vv");
    endtask

    task automatic t_sv();
        setlen(13);
        run("R4 sadd", 0, 3, 1, 0, 1, 0, 0, 32'hF000_0123);
        run("R4 smul", 2, 4, 2, 0, 1, 0, 0, 32'h0001_0003);
        check_all("R4 R5 scalar short");
    endtask

    task automatic t_cmp();
        setlen(32);
        run("R6 cne", 4, 1, 1, 2, 0, 0, 0, 0);
        setlen(10);
        run("R6 ceq", 3, 1, 1, 2, 0, 0, 0, 0);
        check_all("R6 R5 compare");
    endtask

    task automatic t_masked();
        setlen(32);
        run("R7 msub", 1, 7, 1, 2, 0, 1, 1, 0);
        run("R7 mask0", 0, 6, 1, 1, 0, 1, 0, 0);
        check_all("R7 masked");
    endtask

    task automatic t_zero();
        setlen(0);
        run("R9 zero", 0, 3, 1, 1, 0, 0, 0, 0);
        run("R9 zero cmp", 3, 0, 1, 1, 0, 0, 0, 0);
        check_all("R9 zero length");
    endtask

    task automatic t_busy();
        setlen(32);
        issue(0, 3, 1, 2, 0, 0, 0, 0);
        in_valid = 1'b1; in_op = 3'd2; in_dst = 3'd4; in_srca = 3'd1; in_srcb = 3'd1;
        len_we = 1'b1; len_wdata = 8'd5;
        @(negedge clk);
        len_we = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        wait_done();
        model(0, 3, 1, 2, 0, 0, 0, 0, 32);
        mlen = 5;
        chk("R11 new len", 32'(len_q), 32'd5);
        chk("R10 ready after", 32'(in_ready), 32'd1);
        check_all("R10 R11 busy");
    endtask

    task automatic t_collide();
        setlen(32);
        issue(0, 6, 1, 0, 1, 0, 0, 32'h0000_0100);
        @(negedge clk);
        el_we = 1'b1; el_reg = 3'd6; el_idx = 5'd5; el_wdata = 32'hDEAD_0005;
        @(negedge clk);
        el_idx = 5'd2; el_wdata = 32'hBEEF_0002;
        @(negedge clk);
        el_we = 1'b0;
        wait_done();
        model(0, 6, 1, 0, 1, 0, 0, 32'h0000_0100, 32);
        mv[6][2] = 32'hBEEF_0002;
        el_reg = 3'd6; el_idx = 5'd5; #1;
        chk("R12 collide result wins", el_rdata, mv[6][5]);
        el_idx = 5'd2; #1;
        chk("R12 other element stored", el_rdata, 32'hBEEF_0002);
        check_all("R12 collide");
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog R8: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 32; i++)
                mv[r][i] = '0;
        mm[0] = '1;
        mm[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        for (int i = 0; i < 32; i++) begin
            wr(1, i, 32'h9E37_79B9 * 32'(i + 1));
            wr(2, i, (i % 3 == 0) ? 32'h9E37_79B9 * 32'(i + 1) : 32'(i * 977 + 5));
        end
        t_len();
        t_vv();
        t_sv();
        t_cmp();
        t_masked();
        t_zero();
        t_busy();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule